// File: doc/BRIEF.md
# Red-Then-Green Event Detector

This block watches a two-bit traffic-light code, one sample per clock, and raises a one-cycle pulse when a green light shows up at some point after a red light. One bit of state records whether a red has been seen since reset or since the last pulse. A green that arrives while that bit is clear does nothing. A green that arrives while it is set drives the output high in that same cycle and clears the bit.

The output is Mealy: it is formed combinationally from the stored bit and the current light code. Downstream logic should register it if it needs a clean timing boundary. Reset is synchronous and active high.

Top module: `red_green_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored state becomes 0 ("no red seen"). With state 0, `hit` is 0 for every light code.
- R2: Light codes are 2'b01 = red and 2'b10 = green. Codes 2'b00 and 2'b11 are neither red nor green.
- R3: In state 0, a non-red code (00, 10, 11) leaves the state at 0, and `hit` is 0. A green in state 0 produces no pulse.
- R4: In state 0, the red code 01 sets the state to 1 at the next edge, and `hit` is 0 in that cycle.
- R5: In state 1, any non-green code (00, 01, 11) keeps the state at 1, and `hit` is 0. Repeated reds are absorbed.
- R6: In state 1, the green code 10 makes `hit` 1 combinationally in that same cycle, and the state returns to 0 at the next edge.
- R7: `hit` is high only when the state is 1 and the current code is green. Two consecutive greens after a red give exactly one pulse.
- R8: Reset takes priority over the light input. Red with `rst` high still leaves state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| light | input | 2 | Light code: 01 red, 10 green, others neutral |
| hit | output | 1 | Mealy pulse: green seen after a prior red |

## Verification
The hardest case to reach is a green arriving after a long run of neutral codes and repeated reds, because the only sign that the stored bit is still set is the eventual pulse. The stimulus mixes directed runs with random codes that are weighted toward neutral values, so long gaps between red and green occur often. It also asserts reset in the middle of a pending red to check that the pending state is cleared.

// File: rtl/red_green_detect.sv
module red_green_detect #(
  parameter logic [1:0] RED_CODE   = 2'b01,
  parameter logic [1:0] GREEN_CODE = 2'b10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] light,
  output logic       hit
);

  logic armed;
  logic is_red;
  logic is_green;

  assign is_red   = (light == RED_CODE);
  assign is_green = (light == GREEN_CODE);
  assign hit      = armed & is_green;

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (!armed && is_red)
      armed <= 1'b1;
    else if (armed && is_green)
      armed <= 1'b0;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !armed);
  // R4
  red_arms_chk: assert property (@(posedge clk) disable iff (rst) (!armed && is_red) |=> armed);
  // R5
  hold_armed_chk: assert property (@(posedge clk) disable iff (rst) (armed && !is_green) |=> armed);
  // R6
  green_disarms_chk: assert property (@(posedge clk) disable iff (rst) hit |=> !armed);
  // R3
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst) (!armed && !is_red) |=> !armed);
  // R7
  hit_needs_red_chk: assert property (@(posedge clk) disable iff (rst) hit |-> $past(is_red) || $past(armed));

endmodule

// File: tb/red_green_detect_tb.sv
module red_green_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst;
  logic [1:0] light;
  logic hit;

  int vectors = 0;
  int errors = 0;
  bit model_armed;
  bit done = 0;

  red_green_detect dut_i (.clk(clk), .rst(rst), .light(light), .hit(hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_hit(bit armed, logic [1:0] l);
    return armed && (l == 2'b10);
  endfunction

  function automatic bit exp_next(bit armed, logic [1:0] l, logic r);
    if (r) return 1'b0;
    if (!armed) return (l == 2'b01);
    return (l != 2'b10);
  endfunction

  task automatic step(input logic r, input logic [1:0] l, input string req);
    rst = r;
    light = l;
    #1;
    vectors++;
    if (hit !== (r ? model_armed && (l == 2'b10) : exp_hit(model_armed, l))) begin
      errors++;
      $display("FAIL %s: light=%b rst=%b hit=%b expected %b", req, l, r, hit,
               exp_hit(model_armed, l));
    end
    @(posedge clk);
    model_armed = exp_next(model_armed, l, r);
    #(CLK_PERIOD/2 - 1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd465));
    rst = 1; light = 2'b00;
    @(posedge clk); #(CLK_PERIOD/2);
    model_armed = 0;
    // R1: after reset, green gives no hit
    step(0, 2'b10, "R1");
    // R3 neutral codes in idle
    step(0, 2'b00, "R3");
    step(0, 2'b11, "R3");
    step(0, 2'b10, "R3");
    // R4 arm, R5 hold through reds/neutrals, R6 fire
    step(0, 2'b01, "R4");
    step(0, 2'b01, "R5");
    step(0, 2'b00, "R5");
    step(0, 2'b11, "R5");
    step(0, 2'b10, "R6");
    // R7: second green gives no pulse
    step(0, 2'b10, "R7");
    // R2 codes: red immediately followed by green
    step(0, 2'b01, "R2");
    step(0, 2'b10, "R2");
    // R8: reset with red, then green -> no hit
    step(1, 2'b01, "R8");
    step(0, 2'b10, "R8");
    // R1: reset while armed clears
    step(0, 2'b01, "R1");
    step(1, 2'b00, "R1");
    step(0, 2'b10, "R1");
    // random, weighted toward neutral codes
    for (int i = 0; i < 3000; i++) begin
      int p;
      logic [1:0] l;
      p = $urandom_range(0, 99);
      if (p < 15) l = 2'b01;
      else if (p < 35) l = 2'b10;
      else if (p < 70) l = 2'b00;
      else l = 2'b11;
      step(($urandom_range(0, 199) == 0), l, "R7");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule